// File: doc/BRIEF.md
# Two-Task Banked Memory Mapper

This block maps the 64K address space of an 8-bit CPU onto a larger physical memory made of 8K blocks. The three top address bits pick one of eight slots. Each slot has a bank register that holds the physical block number. There are two complete sets of eight bank registers. A single task bit chooses which set translates CPU accesses, so system and user contexts can switch in one write.

Translation is purely combinational. The CPU address goes in, and out come a 6-bit block number plus exactly one select among RAM, ROM and I/O. Three special cases sit on top of the slot lookup:
- An optional fixed window at 0xFE00–0xFEFF always reaches the last RAM block.
- The top 256 bytes are never translated and raise an I/O select.
- A ROM/RAM map mode sends blocks 0x3C–0x3F to ROM. A two-bit layout field then picks internal or external ROM.

A small register port holds the bank registers, a control byte and two write-only strobes that change the map mode. It has a write strobe, a 5-bit offset and 8-bit data, and its read data is combinational.

Top module: `bank_mmu`

## Requirements
- R1: After reset, bank register offset k (0x00–0x0F) reads 0x38 + (k mod 8), the control byte at offset 0x10 reads 0x00, and with these values address 0x2000 maps to RAM block 0x39.
- R2: A write to offset 0x00–0x0F stores the low 6 bits of the data into that bank register. Offsets 0x00–0x07 form task set 0 and 0x08–0x0F form task set 1. A read returns the stored value with bits 7:6 as zero.
- R3: With translation enabled, the slot is CPU address bits 15:13. The block comes from that slot's register in set 0 when the task bit is 0, and from set 1 when the task bit is 1.
- R4: With translation disabled (control bit 0 = 0), slot n maps to block 0x38 + n whatever the bank registers hold.
- R5: When control bit 2 is set, addresses 0xFE00–0xFEFF select RAM block 0x3F in every mode, regardless of the slot 7 register. When the bit is clear, those addresses follow slot 7 like the rest of 0xE000–0xFFFF below the I/O page.
- R6: Addresses 0xFF00–0xFFFF assert the I/O select with RAM and ROM selects low and a block output of 0.
- R7: A write of any value to offset 0x11 enters ROM/RAM mode, and a write of any value to offset 0x12 enters all-RAM mode. The current mode reads back as control bit 5 (1 = ROM/RAM mode), and that bit is not writable through offset 0x10.
- R8: In ROM/RAM mode, a slot whose block lies in 0x3C–0x3F selects ROM instead of RAM. The output block is then 0x3C plus the low two bits of the slot number, whatever the register's low two bits are.
- R9: The ROM layout is control bits 4:3. With 00 or 01, ROM pages with low bits 00 and 01 are internal (rom_ext = 0) and pages 10 and 11 are external. With 10 all pages are internal, and with 11 all are external. rom_ext is 0 whenever ROM is not selected.
- R10: In all-RAM mode no address selects ROM, including blocks 0x3C–0x3F.
- R11: Every CPU address asserts exactly one of ram_sel, rom_sel and io_sel.
- R12: The control byte at offset 0x10 has these fields:
  - bit 0: translation enable
  - bit 1: task select
  - bit 2: constant-page enable
  - bits 4:3: ROM layout

  Writes to offsets 0x13–0x1F change nothing, and those offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| cpu_addr | input | 16 | CPU address to translate |
| phys_block | output | 6 | Physical 8K block or ROM page |
| ram_sel | output | 1 | Access goes to RAM |
| rom_sel | output | 1 | Access goes to ROM |
| rom_ext | output | 1 | Selected ROM page is external |
| io_sel | output | 1 | Access is in the I/O page |

## Verification
The assertions check the following on every cycle:
- exactly one select is active;
- the I/O page and the constant page always win over the slot lookup;
- a ROM hit carries the slot's low bits;
- no ROM is selected in all-RAM mode;
- the mode strobes take effect on the next cycle.

Other behaviour shows only in the bench's scenarios:
- the stored contents of the two register sets and the switch between them;
- the reset defaults;
- the masking of readback bits;
- the layout split of internal and external ROM;
- the inertness of unmapped offsets.

// File: rtl/mmu_pkg.sv
package mmu_pkg;

    typedef enum logic [1:0] {
        LAY_SPLIT_A = 2'b00,
        LAY_SPLIT_B = 2'b01,
        LAY_ALL_INT = 2'b10,
        LAY_ALL_EXT = 2'b11
    } rom_layout_e;

    typedef struct packed {
        logic        rom_mode;
        rom_layout_e layout;
        logic        cpage_en;
        logic        task_sel;
        logic        map_en;
    } mmu_ctrl_t;

    localparam int CTRL_OFF     = 0;
    localparam int ROM_STB_OFF  = 1;
    localparam int RAM_STB_OFF  = 2;

endpackage

// File: rtl/mmu_regfile.sv
module mmu_regfile
    import mmu_pkg::*;
#(
    parameter int SLOT_BITS = 3,
    parameter int BLK_W     = 6,
    parameter int DATA_W    = 8
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic                                       wr_en,
    input  logic [SLOT_BITS+1:0]                       addr,
    input  logic [DATA_W-1:0]                          wdata,
    output logic [DATA_W-1:0]                          rdata,
    output mmu_ctrl_t                                  ctrl,
    output logic [2*(1<<SLOT_BITS)-1:0][BLK_W-1:0]     banks
);
    localparam int SLOTS = 1 << SLOT_BITS;
    localparam int NBANK = 2 * SLOTS;
    localparam int IDX_W = SLOT_BITS + 1;
    localparam int FULL  = 1 << BLK_W;

    typedef struct packed {
        logic [NBANK-1:0][BLK_W-1:0] bank;
        mmu_ctrl_t                   ctrl;
    } state_t;

    state_t st_d, st_q;

    function automatic state_t reset_state();
        state_t r;
        r = '0;
        for (int i = 0; i < NBANK; i++) begin
            r.bank[i] = BLK_W'(FULL - SLOTS + (i % SLOTS));
        end
        return r;
    endfunction

    logic             is_ctrl_space;
    logic [IDX_W-1:0] idx;

    assign is_ctrl_space = addr[IDX_W];
    assign idx           = addr[IDX_W-1:0];

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (!is_ctrl_space) begin
                st_d.bank[idx] = wdata[BLK_W-1:0];
            end else begin
                case (int'(idx))
                    CTRL_OFF: begin
                        st_d.ctrl.map_en   = wdata[0];
                        st_d.ctrl.task_sel = wdata[1];
                        st_d.ctrl.cpage_en = wdata[2];
                        st_d.ctrl.layout   = rom_layout_e'(wdata[4:3]);
                    end
                    ROM_STB_OFF: st_d.ctrl.rom_mode = 1'b1;
                    RAM_STB_OFF: st_d.ctrl.rom_mode = 1'b0;
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= reset_state();
        else        st_q <= st_d;
    end

    always_comb begin
        rdata = '0;
        if (!is_ctrl_space) begin
            rdata = {{(DATA_W-BLK_W){1'b0}}, st_q.bank[idx]};
        end else if (int'(idx) == CTRL_OFF) begin
            rdata = {{(DATA_W-6){1'b0}}, st_q.ctrl.rom_mode, st_q.ctrl.layout,
                     st_q.ctrl.cpage_en, st_q.ctrl.task_sel, st_q.ctrl.map_en};
        end
    end

    assign ctrl  = st_q.ctrl;
    assign banks = st_q.bank;

    // R7: ROM strobe enters ROM/RAM mode on the next cycle
    p_rom_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && is_ctrl_space && int'(idx) == ROM_STB_OFF) |=> st_q.ctrl.rom_mode);

    // R7: RAM strobe leaves ROM/RAM mode on the next cycle
    p_ram_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && is_ctrl_space && int'(idx) == RAM_STB_OFF) |=> !st_q.ctrl.rom_mode);

    // R2: bank registers hold without a write
    p_bank_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(st_q.bank));

endmodule

// File: rtl/mmu_xlate.sv
module mmu_xlate
    import mmu_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int SLOT_BITS = 3,
    parameter int BLK_W     = 6
) (
    input  logic [ADDR_W-1:0]                          cpu_addr,
    input  mmu_ctrl_t                                  ctrl,
    input  logic [2*(1<<SLOT_BITS)-1:0][BLK_W-1:0]     banks,
    output logic [BLK_W-1:0]                           block,
    output logic                                       ram_hit,
    output logic                                       rom_hit,
    output logic                                       io_hit,
    output logic [1:0]                                 rom_page_lo
);
    localparam int PAGE_W = ADDR_W - 8;
    localparam int FIX_W  = BLK_W - SLOT_BITS;

    logic [SLOT_BITS-1:0] slot;
    logic [PAGE_W-1:0]    page_hi;
    logic [BLK_W-1:0]     raw;
    logic                 in_cpage;

    always_comb begin
        slot     = cpu_addr[ADDR_W-1 -: SLOT_BITS];
        page_hi  = cpu_addr[ADDR_W-1 -: PAGE_W];
        io_hit   = (page_hi == '1);
        in_cpage = ctrl.cpage_en && (page_hi == {{(PAGE_W-1){1'b1}}, 1'b0});
        raw      = ctrl.map_en ? banks[{ctrl.task_sel, slot}]
                               : {{FIX_W{1'b1}}, slot};
        rom_hit  = 1'b0;
        ram_hit  = 1'b0;
        block    = '0;
        rom_page_lo = slot[1:0];
        if (io_hit) begin
            block = '0;
        end else if (in_cpage) begin
            ram_hit = 1'b1;
            block   = '1;
        end else if (ctrl.rom_mode && raw[BLK_W-1:2] == '1) begin
            rom_hit = 1'b1;
            block   = {raw[BLK_W-1:2], slot[1:0]};
        end else begin
            ram_hit = 1'b1;
            block   = raw;
        end
    end

endmodule

// File: rtl/mmu_rom_route.sv
module mmu_rom_route
    import mmu_pkg::*;
(
    input  logic        rom_hit,
    input  logic [1:0]  page_lo,
    input  rom_layout_e layout,
    output logic        rom_sel,
    output logic        rom_ext
);
    always_comb begin
        rom_sel = rom_hit;
        rom_ext = 1'b0;
        if (rom_hit) begin
            case (layout)
                LAY_ALL_INT: rom_ext = 1'b0;
                LAY_ALL_EXT: rom_ext = 1'b1;
                default:     rom_ext = page_lo[1];
            endcase
        end
    end
endmodule

// File: rtl/bank_mmu.sv
module bank_mmu
    import mmu_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int SLOT_BITS = 3,
    parameter int BLK_W     = 6,
    parameter int DATA_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [SLOT_BITS+1:0] reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    input  logic [ADDR_W-1:0]    cpu_addr,
    output logic [BLK_W-1:0]     phys_block,
    output logic                 ram_sel,
    output logic                 rom_sel,
    output logic                 rom_ext,
    output logic                 io_sel
);
    localparam int SLOTS  = 1 << SLOT_BITS;
    localparam int NBANK  = 2 * SLOTS;
    localparam int PAGE_W = ADDR_W - 8;
    localparam int FIX_W  = BLK_W - SLOT_BITS;

    mmu_ctrl_t                   ctrl;
    logic [NBANK-1:0][BLK_W-1:0] banks;
    logic                        rom_hit;
    logic [1:0]                  page_lo;

    mmu_regfile #(.SLOT_BITS(SLOT_BITS), .BLK_W(BLK_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .ctrl(ctrl), .banks(banks)
    );

    mmu_xlate #(.ADDR_W(ADDR_W), .SLOT_BITS(SLOT_BITS), .BLK_W(BLK_W)) u_xlate (
        .cpu_addr(cpu_addr), .ctrl(ctrl), .banks(banks), .block(phys_block),
        .ram_hit(ram_sel), .rom_hit(rom_hit), .io_hit(io_sel), .rom_page_lo(page_lo)
    );

    mmu_rom_route u_route (
        .rom_hit(rom_hit), .page_lo(page_lo), .layout(ctrl.layout),
        .rom_sel(rom_sel), .rom_ext(rom_ext)
    );

    // R11: exactly one target is selected
    p_one_target_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({ram_sel, rom_sel, io_sel}) == 1);

    // R6: top page is always I/O
    p_io_page_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[ADDR_W-1 -: PAGE_W] == '1) |-> (io_sel && phys_block == '0));

    // R5: constant page wins over slot 7 and map mode
    p_const_page_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.cpage_en && cpu_addr[ADDR_W-1 -: PAGE_W] == {{(PAGE_W-1){1'b1}}, 1'b0})
        |-> (ram_sel && phys_block == '1));

    // R10: no ROM in all-RAM mode
    p_no_rom_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.rom_mode |-> !rom_sel);

    // R8: ROM page low bits come from the slot
    p_rom_page_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rom_sel |-> (phys_block[BLK_W-1:2] == '1 && phys_block[1:0] == cpu_addr[ADDR_W-SLOT_BITS+1 -: 2]));

    // R4: disabled translation gives the fixed top blocks
    p_map_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.map_en && ram_sel && !(ctrl.cpage_en && cpu_addr[ADDR_W-1 -: PAGE_W] == {{(PAGE_W-1){1'b1}}, 1'b0}))
        |-> (phys_block[BLK_W-1 -: FIX_W] == '1 && phys_block[SLOT_BITS-1:0] == cpu_addr[ADDR_W-1 -: SLOT_BITS]));

    // R9: external flag only accompanies ROM
    p_ext_only_rom_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rom_ext |-> rom_sel);

endmodule

// File: tb/bank_mmu_test.sv
module bank_mmu_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [15:0] cpu_addr = '0;
    logic [5:0]  phys_block;
    logic        ram_sel, rom_sel, rom_ext, io_sel;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    bank_mmu uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_addr(cpu_addr),
        .phys_block(phys_block), .ram_sel(ram_sel), .rom_sel(rom_sel),
        .rom_ext(rom_ext), .io_sel(io_sel)
    );

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [4:0] a, logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_check(string tag, logic [4:0] a, logic [7:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(tag, {8'h0, reg_rdata}, {8'h0, exp});
    endtask

    // checks block and all three selects plus the external flag (R11 on each)
    task automatic xl(string tag, logic [15:0] a, logic [5:0] blk,
                      logic ram, logic rom, logic io, logic ext);
        @(negedge clk);
        cpu_addr = a;
        #1;
        check({tag, " block"}, {10'h0, phys_block}, {10'h0, blk});
        check({tag, " R11 selects"}, {13'h0, ram_sel, rom_sel, io_sel}, {13'h0, ram, rom, io});
        check({tag, " ext"}, {15'h0, rom_ext}, {15'h0, ext});
    endtask

    task automatic t_reset;
        for (int k = 0; k < 16; k++) rd_check("R1 bank default", 5'(k), 8'(8'h38 + (k % 8)));
        rd_check("R1 ctrl default", 5'h10, 8'h00);
        xl("R1 default map", 16'h2000, 6'h39, 1, 0, 0, 0);
    endtask

    task automatic t_regs;
        wr(5'h03, 8'hFF);
        rd_check("R2 upper bits zero", 5'h03, 8'h3F);
        wr(5'h0B, 8'h15);
        rd_check("R2 set1 store", 5'h0B, 8'h15);
        rd_check("R2 set0 untouched", 5'h03, 8'h3F);
        wr(5'h10, 8'h1F);
        rd_check("R12 ctrl fields", 5'h10, 8'h1F);
        wr(5'h13, 8'hFF);
        wr(5'h1F, 8'h00);
        rd_check("R12 unmapped write ignored", 5'h10, 8'h1F);
        rd_check("R12 unmapped reads zero", 5'h13, 8'h00);
        wr(5'h10, 8'h20);
        rd_check("R7 mode bit not writable", 5'h10, 8'h00);
    endtask

    task automatic t_task;
        wr(5'h02, 8'h05);
        wr(5'h0A, 8'h22);
        wr(5'h10, 8'h01);
        xl("R3 task0 slot2", 16'h4123, 6'h05, 1, 0, 0, 0);
        wr(5'h10, 8'h03);
        xl("R3 task1 slot2", 16'h5FFF, 6'h22, 1, 0, 0, 0);
        xl("R3 task1 slot3", 16'h6000, 6'h15, 1, 0, 0, 0);
        wr(5'h10, 8'h01);
        xl("R3 task0 slot3", 16'h7FFF, 6'h3F, 1, 0, 0, 0);
    endtask

    task automatic t_disable;
        wr(5'h10, 8'h00);
        xl("R4 off slot5", 16'hA000, 6'h3D, 1, 0, 0, 0);
        xl("R4 off slot2", 16'h4000, 6'h3A, 1, 0, 0, 0);
    endtask

    task automatic t_cpage;
        wr(5'h07, 8'h10);
        wr(5'h10, 8'h05);
        xl("R5 const page", 16'hFE40, 6'h3F, 1, 0, 0, 0);
        xl("R5 below page", 16'hFDFF, 6'h10, 1, 0, 0, 0);
        wr(5'h10, 8'h01);
        xl("R5 cpage off", 16'hFE40, 6'h10, 1, 0, 0, 0);
    endtask

    task automatic t_io;
        xl("R6 io low", 16'hFF00, 6'h00, 0, 0, 1, 0);
        xl("R6 io high", 16'hFFFF, 6'h00, 0, 0, 1, 0);
    endtask

    task automatic t_rom;
        wr(5'h02, 8'h3D);
        wr(5'h10, 8'h05);
        xl("R10 ram mode", 16'h4000, 6'h3D, 1, 0, 0, 0);
        wr(5'h11, 8'h00);
        rd_check("R7 rom mode bit", 5'h10, 8'h25);
        xl("R8 slot replaces low bits", 16'h4000, 6'h3E, 0, 1, 0, 1);
        xl("R8 non-rom block", 16'h2000, 6'h39, 1, 0, 0, 0);
        xl("R5 cpage in rom mode", 16'hFE00, 6'h3F, 1, 0, 0, 0);
        wr(5'h12, 8'h5A);
        rd_check("R7 ram mode bit", 5'h10, 8'h05);
        xl("R10 back to ram", 16'h4000, 6'h3D, 1, 0, 0, 0);
    endtask

    task automatic t_layout;
        wr(5'h11, 8'hFF);
        wr(5'h10, 8'h00);
        xl("R9 split p0", 16'h8000, 6'h3C, 0, 1, 0, 0);
        xl("R9 split p1", 16'hA000, 6'h3D, 0, 1, 0, 0);
        xl("R9 split p2", 16'hC000, 6'h3E, 0, 1, 0, 1);
        xl("R9 split p3", 16'hE000, 6'h3F, 0, 1, 0, 1);
        xl("R9 low ram", 16'h0000, 6'h38, 1, 0, 0, 0);
        wr(5'h10, 8'h08);
        xl("R9 split alt p1", 16'hA000, 6'h3D, 0, 1, 0, 0);
        xl("R9 split alt p3", 16'hE000, 6'h3F, 0, 1, 0, 1);
        wr(5'h10, 8'h10);
        xl("R9 all int p2", 16'hC000, 6'h3E, 0, 1, 0, 0);
        xl("R9 all int p3", 16'hE100, 6'h3F, 0, 1, 0, 0);
        wr(5'h10, 8'h18);
        xl("R9 all ext p0", 16'h8000, 6'h3C, 0, 1, 0, 1);
        xl("R9 all ext p1", 16'hBFFF, 6'h3D, 0, 1, 0, 1);
        xl("R6 io in rom mode", 16'hFF80, 6'h00, 0, 0, 1, 0);
        wr(5'h12, 8'h00);
        xl("R10 ram mode p3", 16'hE000, 6'h3F, 1, 0, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_regs;
        t_task;
        t_disable;
        t_cpage;
        t_io;
        t_rom;
        t_layout;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule